// File: doc/BRIEF.md
# T1 Transmit Superframe Overhead Generator

This block keeps the transmit position inside a T1 line signal: the bit inside the 193-bit frame (one overhead bit, then 24 eight-bit time slots sent most significant bit first) and the frame inside the superframe. It advances one bit position for every cycle in which `bit_en` is high. At a 1.544 Mb/s line rate that gives 8000 frames per second. For every position it reports whether the overhead slot is current, and in that slot it supplies the overhead bit value.

Two superframe formats are supported. The 12-frame format places a terminal framing sequence in the odd frames and a signalling-framing sequence in the even frames. The 24-frame extended format interleaves three things in the overhead slots: a six-bit framing pattern, the six bits of the CRC-6 remainder computed over the previous superframe, and a 4 kHz data link. The CRC remainder comes from an external checker. The data-link bits arrive over a valid/ready stream. The block also marks the frames in which robbed-bit signalling replaces the least significant bit of every channel byte, and names the signalling bit that applies (A, B, C or D).

Data-link stream rules: `dl_ready_o` rises only in the cycle in which the overhead slot of an extended-format odd frame is being consumed (`bit_en` high). A bit is transferred when `dl_valid_i` and `dl_ready_o` are both high. If the source is not valid at that moment, the block sends an idle 1 and does not wait. The source can therefore never stall the line.

Top module: `t1_ovh_gen`

## Requirements
- R1: After reset the position is frame 1, bit 0, and the 12-frame format is in use (`esf_active_o` = 0). The held CRC value is all zeros.
- R2: The position advances only in cycles with `bit_en` high. The bit index counts from 0 to SLOTS*SLOT_BITS, then wraps to 0 and increments the frame. The frame number wraps from 12 (12-frame format) or 24 (extended format) back to 1.
- R3: `oh_slot_o` is high exactly when the bit index is 0. `sf_start_o` is high exactly at bit 0 of frame 1.
- R4: In the 12-frame format, the overhead bits of frames 1, 3, 5, 7, 9 and 11 are 1, 0, 1, 0, 1, 0.
- R5: In the 12-frame format, the overhead bits of frames 2, 4, 6, 8, 10 and 12 are 0, 0, 1, 1, 1, 0.
- R6: In the extended format, the overhead bits of frames 4, 8, 12, 16, 20 and 24 are 0, 0, 1, 0, 1, 1.
- R7: In the extended format, frames 2, 6, 10, 14, 18 and 22 carry C1 to C6 in that order, where C1 is bit 5 of the held CRC value and C6 is bit 0.
- R8: The held CRC value loads `crc6_i` only when the position advances out of the last bit of the last frame of a superframe. At all other times changes on `crc6_i` have no effect on the overhead bits.
- R9: In the extended format, odd frames carry the data link. The overhead bit is `dl_bit_i` when `dl_valid_i` is high and 1 otherwise. `dl_ready_o` is high only when `bit_en` is high in the overhead slot of such a frame.
- R10: `sig_frame_o` is high for the whole of frames 6 and 12 in the 12-frame format, and for frames 6, 12, 18 and 24 in the extended format. `sig_sel_o` is 0, 1, 2 or 3 for the A, B, C or D bit respectively: A in frame 6, B in frame 12, C in frame 18, D in frame 24. `sig_sel_o` is 0 in all other frames.
- R11: A change on `esf_mode_i` (1 = extended, 0 = 12-frame) takes effect only at the advance out of the last bit of a superframe. `esf_active_o` shows the format in use.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Advance one line bit position this cycle |
| esf_mode_i | input | 1 | Requested format: 1 extended 24-frame, 0 12-frame |
| crc6_i | input | 6 | CRC-6 remainder from the external checker |
| dl_valid_i | input | 1 | Data-link bit is available |
| dl_bit_i | input | 1 | Data-link bit value |
| dl_ready_o | output | 1 | Data-link bit consumed this cycle |
| oh_slot_o | output | 1 | Current position is the overhead bit |
| sf_start_o | output | 1 | Current position is bit 0 of frame 1 |
| oh_bit_o | output | 1 | Overhead bit value for the current frame |
| frame_num_o | output | 5 | Frame number within superframe, 1 to 24 |
| bit_pos_o | output | BW | Bit index within frame, 0 = overhead |
| sig_frame_o | output | 1 | Robbed-bit signalling frame |
| sig_sel_o | output | 2 | Signalling bit in use: 0 A, 1 B, 2 C, 3 D |
| esf_active_o | output | 1 | Format currently in use |

## Verification
The bench builds the block with SLOTS=2 and SLOT_BITS=2, so a frame is only 5 positions long and an extended superframe is 120. A few thousand cycles then cover many superframe boundaries, several format switches requested in mid-superframe, CRC reloads while `crc6_i` changes every cycle, and data-link slots with and without a valid source. The design derives every count from the two parameters, so the default 24-slot, 8-bit frame uses the same logic with wider counters.

// File: rtl/t1_ovh_pkg.sv
package t1_ovh_pkg;
  localparam int FNUM_W     = 5;
  localparam int D4_FRAMES  = 12;
  localparam int ESF_FRAMES = 24;
  localparam int CRC_W      = 6;

  typedef enum logic {
    FMT_D4  = 1'b0,
    FMT_ESF = 1'b1
  } sf_fmt_e;

  typedef enum logic [1:0] {
    SIG_A = 2'd0,
    SIG_B = 2'd1,
    SIG_C = 2'd2,
    SIG_D = 2'd3
  } sig_bit_e;

  // index 0 is the first pattern position in the superframe
  localparam logic [0:5] SIGFRM_PAT = 6'b001110;
  localparam logic [0:5] ESFFRM_PAT = 6'b001011;

  function automatic logic [FNUM_W-1:0] last_frame(input sf_fmt_e fmt);
    return (fmt == FMT_ESF) ? FNUM_W'(ESF_FRAMES) : FNUM_W'(D4_FRAMES);
  endfunction
endpackage

// File: rtl/t1_ovh_timebase.sv
module t1_ovh_timebase
  import t1_ovh_pkg::*;
#(
  parameter int SLOTS     = 24,
  parameter int SLOT_BITS = 8,
  localparam int FRAME_BITS = SLOTS * SLOT_BITS + 1,
  localparam int BW         = $clog2(FRAME_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              esf_req,
  output logic [BW-1:0]     bit_pos,
  output logic [FNUM_W-1:0] frame_num,
  output sf_fmt_e           fmt,
  output logic              sf_wrap
);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);

  logic frame_wrap;

  assign frame_wrap = bit_en && (bit_pos == LAST_BIT);
  assign sf_wrap    = frame_wrap && (frame_num == last_frame(fmt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_pos <= '0;
    end else if (frame_wrap) begin
      bit_pos <= '0;
    end else if (bit_en) begin
      bit_pos <= bit_pos + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_num <= FNUM_W'(1);
    end else if (sf_wrap) begin
      frame_num <= FNUM_W'(1);
    end else if (frame_wrap) begin
      frame_num <= frame_num + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt <= FMT_D4;
    end else if (sf_wrap) begin
      fmt <= esf_req ? FMT_ESF : FMT_D4;
    end
  end
endmodule

// File: rtl/t1_ovh_crc_hold.sv
module t1_ovh_crc_hold #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load) begin
      q <= d;
    end
  end
endmodule

// File: rtl/t1_ovh_oh_mux.sv
module t1_ovh_oh_mux
  import t1_ovh_pkg::*;
(
  input  sf_fmt_e           fmt,
  input  logic [FNUM_W-1:0] frame_num,
  input  logic [CRC_W-1:0]  crc,
  input  logic              dl_valid,
  input  logic              dl_bit,
  output logic              oh_bit,
  output logic              dl_frame,
  output logic              sig_frame,
  output sig_bit_e          sig_sel
);
  logic [2:0] half_idx;
  logic [2:0] quad_idx;
  logic [2:0] six_idx;
  logic       mult6;

  always_comb begin
    half_idx = 3'(frame_num >> 1);
    quad_idx = 3'(frame_num >> 2);
    mult6    = (frame_num % FNUM_W'(6)) == '0;
    six_idx  = 3'(frame_num / FNUM_W'(6));
  end

  always_comb begin
    oh_bit   = 1'b1;
    dl_frame = 1'b0;
    if (fmt == FMT_D4) begin
      if (frame_num[0]) begin
        oh_bit = ~half_idx[0];
      end else begin
        oh_bit = SIGFRM_PAT[half_idx - 3'd1];
      end
    end else begin
      unique case (frame_num[1:0])
        2'b00:   oh_bit = ESFFRM_PAT[quad_idx - 3'd1];
        2'b10:   oh_bit = crc[3'd5 - quad_idx];
        default: begin
          dl_frame = 1'b1;
          oh_bit   = dl_valid ? dl_bit : 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    sig_frame = 1'b0;
    sig_sel   = SIG_A;
    if (fmt == FMT_D4) begin
      if (frame_num == FNUM_W'(6)) begin
        sig_frame = 1'b1;
        sig_sel   = SIG_A;
      end else if (frame_num == FNUM_W'(12)) begin
        sig_frame = 1'b1;
        sig_sel   = SIG_B;
      end
    end else if (mult6) begin
      sig_frame = 1'b1;
      sig_sel   = sig_bit_e'(2'(six_idx - 3'd1));
    end
  end
endmodule

// File: rtl/t1_ovh_gen.sv
module t1_ovh_gen
  import t1_ovh_pkg::*;
#(
  parameter int SLOTS     = 24,
  parameter int SLOT_BITS = 8,
  localparam int FRAME_BITS = SLOTS * SLOT_BITS + 1,
  localparam int BW         = $clog2(FRAME_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              esf_mode_i,
  input  logic [5:0]        crc6_i,
  input  logic              dl_valid_i,
  input  logic              dl_bit_i,
  output logic              dl_ready_o,
  output logic              oh_slot_o,
  output logic              sf_start_o,
  output logic              oh_bit_o,
  output logic [4:0]        frame_num_o,
  output logic [BW-1:0]     bit_pos_o,
  output logic              sig_frame_o,
  output logic [1:0]        sig_sel_o,
  output logic              esf_active_o
);
  logic [BW-1:0]     bit_pos;
  logic [FNUM_W-1:0] frame_num;
  sf_fmt_e           fmt;
  logic              sf_wrap;
  logic [CRC_W-1:0]  crc_q;
  logic              dl_frame;
  sig_bit_e          sig_sel;

  t1_ovh_timebase #(
    .SLOTS     (SLOTS),
    .SLOT_BITS (SLOT_BITS)
  ) u_timebase (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .esf_req   (esf_mode_i),
    .bit_pos   (bit_pos),
    .frame_num (frame_num),
    .fmt       (fmt),
    .sf_wrap   (sf_wrap)
  );

  t1_ovh_crc_hold #(
    .W (CRC_W)
  ) u_crc_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (sf_wrap),
    .d     (crc6_i),
    .q     (crc_q)
  );

  t1_ovh_oh_mux u_oh_mux (
    .fmt       (fmt),
    .frame_num (frame_num),
    .crc       (crc_q),
    .dl_valid  (dl_valid_i),
    .dl_bit    (dl_bit_i),
    .oh_bit    (oh_bit_o),
    .dl_frame  (dl_frame),
    .sig_frame (sig_frame_o),
    .sig_sel   (sig_sel)
  );

  assign oh_slot_o    = (bit_pos == '0);
  assign sf_start_o   = oh_slot_o && (frame_num == FNUM_W'(1));
  assign dl_ready_o   = bit_en && oh_slot_o && dl_frame;
  assign frame_num_o  = frame_num;
  assign bit_pos_o    = bit_pos;
  assign sig_sel_o    = sig_sel;
  assign esf_active_o = (fmt == FMT_ESF);
endmodule

// File: rtl/t1_ovh_gen_chk.sv
module t1_ovh_gen_chk #(
  parameter int BW = 8,
  parameter int FRAME_BITS = 193
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_en,
  input logic          esf_mode_i,
  input logic          dl_ready_o,
  input logic          oh_slot_o,
  input logic          sf_start_o,
  input logic [4:0]    frame_num_o,
  input logic [BW-1:0] bit_pos_o,
  input logic          sig_frame_o,
  input logic          esf_active_o
);
  logic last_bit;
  logic sf_edge;
  assign last_bit = bit_pos_o == BW'(FRAME_BITS - 1);
  assign sf_edge  = bit_en && last_bit &&
                    (frame_num_o == (esf_active_o ? 5'd24 : 5'd12));

  // R2
  hold_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(bit_pos_o) && $stable(frame_num_o)));

  // R2
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && last_bit) |=> (bit_pos_o == '0 && !$stable(frame_num_o)));

  // R3
  sf_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sf_start_o |-> (oh_slot_o && frame_num_o == 5'd1));

  // R9
  dl_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dl_ready_o |-> (bit_en && oh_slot_o && esf_active_o && frame_num_o[0]));

  // R10
  sig_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sig_frame_o |-> (frame_num_o % 5'd6 == 5'd0));

  // R11
  fmt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sf_edge |=> $stable(esf_active_o));

  // R11
  fmt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sf_edge |=> (esf_active_o == $past(esf_mode_i)));
endmodule

bind t1_ovh_gen t1_ovh_gen_chk #(
  .BW         (BW),
  .FRAME_BITS (FRAME_BITS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bit_en       (bit_en),
  .esf_mode_i   (esf_mode_i),
  .dl_ready_o   (dl_ready_o),
  .oh_slot_o    (oh_slot_o),
  .sf_start_o   (sf_start_o),
  .frame_num_o  (frame_num_o),
  .bit_pos_o    (bit_pos_o),
  .sig_frame_o  (sig_frame_o),
  .esf_active_o (esf_active_o)
);

// File: tb/t1_ovh_gen_bench.sv
module t1_ovh_gen_bench;
  localparam int SLOTS = 2;
  localparam int SLOT_BITS = 2;
  localparam int FB = SLOTS * SLOT_BITS + 1;
  localparam int BW = $clog2(FB);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0;
  logic esf_mode = 1'b0;
  logic [5:0] crc6 = '0;
  logic dl_valid = 1'b0;
  logic dl_bit = 1'b0;
  logic dl_ready, oh_slot, sf_start, oh_bit, sig_frame, esf_active;
  logic [4:0] frame_num;
  logic [BW-1:0] bit_pos;
  logic [1:0] sig_sel;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  int m_bit = 0, m_frame = 1, m_esf = 0, m_crc = 0;
  int fs_seq[6]  = '{0, 0, 1, 1, 1, 0};
  int fps_seq[6] = '{0, 0, 1, 0, 1, 1};

  always #2 clk = ~clk;

  t1_ovh_gen #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_t1_ovh_gen (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .esf_mode_i(esf_mode),
    .crc6_i(crc6), .dl_valid_i(dl_valid), .dl_bit_i(dl_bit),
    .dl_ready_o(dl_ready), .oh_slot_o(oh_slot), .sf_start_o(sf_start),
    .oh_bit_o(oh_bit), .frame_num_o(frame_num), .bit_pos_o(bit_pos),
    .sig_frame_o(sig_frame), .sig_sel_o(sig_sel), .esf_active_o(esf_active)
  );

  // reference model of the position, format and held CRC
  always @(posedge clk or negedge rst_n) begin
    cycles++;
    if (!rst_n) begin
      m_bit = 0; m_frame = 1; m_esf = 0; m_crc = 0;
    end else if (bit_en) begin
      if (m_bit == FB - 1) begin
        m_bit = 0;
        if (m_frame == (m_esf != 0 ? 24 : 12)) begin
          m_frame = 1;
          m_esf = int'(esf_mode);
          m_crc = int'(crc6);
        end else begin
          m_frame++;
        end
      end else begin
        m_bit++;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s frame %0d bit %0d: actual %0d expected %0d",
               req, m_frame, m_bit, act, exp);
    end
  endtask

  function automatic string oh_req();
    if (m_esf == 0) return (m_frame % 2 == 1) ? "R4" : "R5";
    if (m_frame % 4 == 0) return "R6";
    if (m_frame % 4 == 2) return "R7/R8";
    return "R9";
  endfunction

  function automatic int exp_oh();
    if (m_esf == 0) begin
      if (m_frame % 2 == 1) return (((m_frame - 1) / 2) % 2 == 0) ? 1 : 0;
      return fs_seq[m_frame / 2 - 1];
    end
    if (m_frame % 4 == 0) return fps_seq[m_frame / 4 - 1];
    if (m_frame % 4 == 2) return (m_crc >> (5 - (m_frame - 2) / 4)) & 1;
    return dl_valid ? int'(dl_bit) : 1;
  endfunction

  task automatic compare_all();
    int sigf, sigs;
    chk("R2", int'(bit_pos), m_bit);
    chk("R2", int'(frame_num), m_frame);
    chk("R3", int'(oh_slot), int'(m_bit == 0));
    chk("R3", int'(sf_start), int'(m_bit == 0 && m_frame == 1));
    chk("R11", int'(esf_active), m_esf);
    chk(oh_req(), int'(oh_bit), exp_oh());
    chk("R9", int'(dl_ready),
        int'(bit_en && m_bit == 0 && m_esf != 0 && m_frame % 2 == 1));
    if (m_esf == 0) sigf = int'(m_frame == 6 || m_frame == 12);
    else sigf = int'(m_frame % 6 == 0);
    sigs = (sigf != 0) ? ((m_esf == 0) ? (m_frame / 6 - 1) : (m_frame / 6 - 1)) : 0;
    chk("R10", int'(sig_frame), sigf);
    chk("R10", int'(sig_sel), sigs);
  endtask

  task automatic run(input int n, input int en_pct);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_en   = ($urandom_range(99) < en_pct);
      crc6     = 6'($urandom);
      dl_valid = $urandom_range(1);
      dl_bit   = $urandom_range(1);
      #1;
      compare_all();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", int'(frame_num), 1);
    chk("R1", int'(bit_pos), 0);
    chk("R1", int'(esf_active), 0);
    chk("R1", int'(oh_bit), 1);
    rst_n = 1'b1;
    run(300, 100);          // 12-frame format, full rate
    esf_mode = 1'b1;        // R11: requested mid-superframe
    run(400, 70);           // extended format, stalls in between
    run(800, 100);
    esf_mode = 1'b0;
    run(700, 50);
    run(300, 100);
    esf_mode = 1'b1;
    run(200, 100);
    @(negedge clk);
    rst_n = 1'b0;
    bit_en = 1'b0;
    #1;
    // R1: reset mid-run
    chk("R1", int'(frame_num), 1);
    chk("R1", int'(bit_pos), 0);
    chk("R1", int'(esf_active), 0);
    @(negedge clk);
    rst_n = 1'b1;
    run(100, 100);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule